// File: doc/BRIEF.md
# Branch target address selector

This block produces the next fetch address for a branch in a processor front end. Each cycle it looks at the current instruction address and a two-bit mode code. It forms one of four candidate targets: an absolute address carried by the instruction, the current address plus a sign-extended 25-bit displacement, the link register, or the count register. It then chooses between that candidate and the sequential address. Decode and condition evaluation happen elsewhere; the block only receives a condition bit.

The link and count registers live inside the block. When a branch resolves, a link-save strobe can capture the return address, and a decrement strobe can step the count register down for counted loops. When the decrement strobe is set, the branch is taken only if the count after the decrement is nonzero. Both registers can also be loaded directly, and their values are visible on output ports.

Top module: `branch_target_sel`

## Requirements
- R1: With mode code 0 (absolute), a taken branch gives `next_pc` equal to `abs_addr` with bits 1:0 cleared.
- R2: With mode code 1 (relative), a taken branch gives `next_pc` equal to `cur_addr` plus `rel_disp` sign-extended from 25 bits, with bits 1:0 cleared; the largest positive and largest negative displacements are reached exactly.
- R3: With mode code 2 (link), a taken branch targets the link register value held before the current edge, even when the same branch also saves a new return address.
- R4: With mode code 3 (count), a taken branch targets the count register value held before the current edge, even when the same branch also decrements it.
- R5: When the branch is not taken, `next_pc` equals `cur_addr + 4` with bits 1:0 cleared.
- R6: On a clock edge with `resolve` and `link_save` both high, the link register becomes `cur_addr + 4`.
- R7: On a clock edge with `resolve` and `ctr_dec` both high, the count register decreases by one and wraps from 0 to all ones. With `ctr_dec` high, the branch is taken only if `cond_true` is high and the decremented count is nonzero.
- R8: Bits 1:0 of `next_pc` are always zero.
- R9: After reset, both the link and count registers read zero.
- R10: `lr_wr` and `ctr_wr` load `wr_data` into the link or count register. If the same edge also has a branch update for that register, the branch update wins.
- R11: With no branch update and no write, the link and count registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_addr | input | AW | Address of the branch instruction |
| abs_addr | input | AW | Absolute target from the instruction |
| rel_disp | input | DW | Signed relative displacement |
| mode | input | 2 | 0 absolute, 1 relative, 2 link, 3 count |
| cond_true | input | 1 | External branch condition |
| resolve | input | 1 | The branch resolves on this edge |
| link_save | input | 1 | Save the return address on resolve |
| ctr_dec | input | 1 | Decrement the count and test it on resolve |
| lr_wr | input | 1 | Direct load of the link register |
| ctr_wr | input | 1 | Direct load of the count register |
| wr_data | input | AW | Data for direct loads |
| next_pc | output | AW | Next fetch address |
| taken | output | 1 | The branch is taken |
| lr_q | output | AW | Link register value |
| ctr_q | output | AW | Count register value |

## Verification
Two functions can fall in the same cycle: a branch that reads a special register as its target, and a strobe that rewrites that same register. Link mode is driven together with `link_save`, and count mode together with `ctr_dec`. The bench checks that `next_pc` shows the old register value before the edge and that the register holds the new value after it. A direct write that collides with a branch update is judged the same way, by reading the register back on its output port.

// File: rtl/branch_target_sel.sv
module branch_target_sel #(
  parameter int AW = 32,
  parameter int DW = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] abs_addr,
  input  logic [DW-1:0] rel_disp,
  input  logic [1:0]    mode,
  input  logic          cond_true,
  input  logic          resolve,
  input  logic          link_save,
  input  logic          ctr_dec,
  input  logic          lr_wr,
  input  logic          ctr_wr,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] next_pc,
  output logic          taken,
  output logic [AW-1:0] lr_q,
  output logic [AW-1:0] ctr_q
);
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] MASK = ~AW'(3);

  logic [AW-1:0] seq_addr, disp_ext, target, ctr_next;
  logic          ctr_ok;

  assign seq_addr = cur_addr + STEP;
  assign disp_ext = {{(AW-DW){rel_disp[DW-1]}}, rel_disp};
  assign ctr_next = ctr_q - AW'(1);
  assign ctr_ok   = !ctr_dec || (ctr_next != '0);
  assign taken    = cond_true && ctr_ok;

  always_comb begin
    case (mode)
      2'd0:    target = abs_addr;
      2'd1:    target = cur_addr + disp_ext;
      2'd2:    target = lr_q;
      default: target = ctr_q;
    endcase
  end

  assign next_pc = (taken ? target : seq_addr) & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q  <= '0;
      ctr_q <= '0;
    end else begin
      if (resolve && link_save) lr_q <= seq_addr;
      else if (lr_wr)           lr_q <= wr_data;
      if (resolve && ctr_dec)   ctr_q <= ctr_next;
      else if (ctr_wr)          ctr_q <= wr_data;
    end
  end
endmodule

// File: rtl/branch_target_sel_chk.sv
module branch_target_sel_chk #(
  parameter int AW = 32,
  parameter int DW = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    mode,
  input logic          cond_true,
  input logic          resolve,
  input logic          link_save,
  input logic          ctr_dec,
  input logic          lr_wr,
  input logic          ctr_wr,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] lr_q,
  input logic [AW-1:0] ctr_q
);
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_true |-> next_pc == ((cur_addr + AW'(4)) & ~AW'(3)));
  a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc[1:0] == 2'b00);
  a_r6_link_save: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && link_save) |=> lr_q == $past(cur_addr) + AW'(4));
  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && ctr_dec) |=> ctr_q == $past(ctr_q) - AW'(1));
  a_r7_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_dec && ctr_q == AW'(1)) |-> next_pc == ((cur_addr + AW'(4)) & ~AW'(3)));
  a_r4_count_target: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && cond_true && !ctr_dec) |-> next_pc == (ctr_q & ~AW'(3)));
  a_r3_link_target: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && cond_true && !ctr_dec) |-> next_pc == (lr_q & ~AW'(3)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!resolve && !lr_wr && !ctr_wr) |=> $stable(lr_q) && $stable(ctr_q));
endmodule

bind branch_target_sel branch_target_sel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .mode(mode),
  .cond_true(cond_true), .resolve(resolve), .link_save(link_save),
  .ctr_dec(ctr_dec), .lr_wr(lr_wr), .ctr_wr(ctr_wr), .next_pc(next_pc),
  .lr_q(lr_q), .ctr_q(ctr_q)
);

// File: tb/tb_branch_target_sel.sv
module tb_branch_target_sel;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cur_addr = 0, abs_addr = 0, wr_data = 0;
  logic [24:0] rel_disp = 0;
  logic [1:0]  mode = 0;
  logic cond_true = 0, resolve = 0, link_save = 0, ctr_dec = 0, lr_wr = 0, ctr_wr = 0;
  logic [31:0] next_pc, lr_q, ctr_q;
  logic        taken;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  branch_target_sel dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    resolve = 0; link_save = 0; ctr_dec = 0; lr_wr = 0; ctr_wr = 0; cond_true = 0;
  endtask

  task automatic write_reg(bit is_ctr, logic [31:0] v);
    idle();
    wr_data = v; lr_wr = !is_ctr; ctr_wr = is_ctr;
    idle();
  endtask

  task automatic t_reset();
    #1;
    check("R9 lr reset", lr_q, 0);
    check("R9 ctr reset", ctr_q, 0);
  endtask

  task automatic t_absolute();
    idle();
    cur_addr = 32'h0000_4000; abs_addr = 32'h1234_5677; mode = 0; cond_true = 1; #1;
    check("R1 absolute", next_pc, 32'h1234_5674);
    check("R8 aligned", {30'd0, next_pc[1:0]}, 0);
  endtask

  task automatic t_relative();
    idle();
    mode = 1; cond_true = 1; cur_addr = 32'h0000_1000; rel_disp = 25'h1FF_FFF8; #1;
    check("R2 negative disp", next_pc, 32'h0000_0FF8);
    rel_disp = 25'h0FF_FFFF; #1;
    check("R2 max positive disp", next_pc, 32'h0100_0FFC);
    cur_addr = 32'h0200_0000; rel_disp = 25'h100_0000; #1;
    check("R2 max negative disp", next_pc, 32'h0100_0000);
  endtask

  task automatic t_not_taken();
    idle();
    mode = 0; abs_addr = 32'hDEAD_0000; cur_addr = 32'h0000_2003; cond_true = 0; #1;
    check("R5 fallthrough", next_pc, 32'h0000_2004);
    check("R5 taken flag", {31'd0, taken}, 0);
  endtask

  task automatic t_link_collide();
    write_reg(0, 32'h0000_8000);
    check("R10 lr write", lr_q, 32'h0000_8000);
    @(negedge clk);
    mode = 2; cond_true = 1; resolve = 1; link_save = 1; cur_addr = 32'h0000_3000; #1;
    check("R3 old lr target", next_pc, 32'h0000_8000);
    @(posedge clk); #1;
    check("R6 lr saved", lr_q, 32'h0000_3004);
  endtask

  task automatic t_count_collide();
    write_reg(1, 32'h0000_0A00);
    @(negedge clk);
    mode = 3; cond_true = 1; resolve = 1; ctr_dec = 1; cur_addr = 32'h0000_5000; #1;
    check("R4 old ctr target", next_pc, 32'h0000_0A00);
    @(posedge clk); #1;
    check("R7 decremented", ctr_q, 32'h0000_09FF);
  endtask

  task automatic t_loop_exit();
    write_reg(1, 32'd1);
    @(negedge clk);
    mode = 0; abs_addr = 32'h0000_7000; cond_true = 1; resolve = 1; ctr_dec = 1;
    cur_addr = 32'h0000_6000; #1;
    check("R7 exit at zero", next_pc, 32'h0000_6004);
    @(posedge clk); #1;
    check("R7 ctr zero", ctr_q, 0);
    @(negedge clk); #1;
    check("R7 wrap taken", next_pc, 32'h0000_7000);
    @(posedge clk); #1;
    check("R7 wrap", ctr_q, 32'hFFFF_FFFF);
  endtask

  task automatic t_write_precedence();
    write_reg(1, 32'd10);
    @(negedge clk);
    resolve = 1; ctr_dec = 1; ctr_wr = 1; wr_data = 32'd99;
    link_save = 1; lr_wr = 1; cur_addr = 32'h0000_9000;
    @(posedge clk); #1;
    check("R10 ctr branch wins", ctr_q, 32'd9);
    check("R10 lr branch wins", lr_q, 32'h0000_9004);
  endtask

  task automatic t_hold();
    idle();
    cur_addr = 32'h0000_AAA0; wr_data = 32'h5555_5555;
    repeat (3) @(posedge clk);
    #1;
    check("R11 lr hold", lr_q, 32'h0000_9004);
    check("R11 ctr hold", ctr_q, 32'd9);
  endtask

  initial begin
    fork
      begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_absolute();
        t_relative();
        t_not_taken();
        t_link_collide();
        t_count_collide();
        t_loop_exit();
        t_write_precedence();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule